// File: doc/BRIEF.md
# Byte-wide boot loader sequencer

This block fills a wide internal program memory from a narrow external byte source. A program word is 24 bits wide and the source delivers 8 bits per fetch. The block reads bytes in ascending address order, gathers each group of three into one word, and writes that word into the program RAM. Once a load has started, nothing outside the block has to step in. The only pacing comes from the source's data-valid line, so a slow source simply holds the loader in place.

A load starts in one of two ways. The first is by itself, right after reset, when the memory-map strap input is low during reset. The second is a software reboot pulse that arrives while the block is idle. A dedicated active-low select output is held low for the whole time the block is fetching bytes. When the configured number of words has been written, the block stops fetching and raises a one-cycle done pulse.

Top module: `bootld_top`

## Requirements
- R1: While reset is active and afterwards, until a load starts: src_sel_n is 1, and pm_we, busy and done are 0.
- R2: If map_strap is 0 while reset is active, a load starts by itself. src_sel_n is low in the cycle after the first rising edge at which rst_n is high.
- R3: If map_strap is 1 while reset is active, the block stays idle after reset. There is no select, no memory write and no done pulse.
- R4: A one-cycle sw_reboot pulse sampled while the block is idle starts a load. src_sel_n goes low two rising edges after the pulse is sampled, and the load begins again at byte address 0 and word address 0.
- R5: src_sel_n is 0 exactly while the block is fetching bytes. It is 1 when the block is idle and in the cycle the done pulse is high.
- R6: The first byte address of a load is 0. src_addr goes up by one for each byte accepted. A byte is accepted at a rising edge where src_sel_n is 0 and src_valid is 1.
- R7: Bytes 3k, 3k+1 and 3k+2 form word k, with the first byte in bits 23:16, the second in bits 15:8 and the third in bits 7:0. In the cycle after the third byte is accepted, pm_we is high for one cycle with pm_addr = k.
- R8: While src_valid is 0 during a fetch, src_addr holds its value, src_sel_n stays low and no word is written.
- R9: After WORDS words the fetch stops. src_sel_n goes high in the cycle the last word is written, and done is high for exactly one cycle, the cycle after that last write.
- R10: A sw_reboot pulse that arrives while a load is in progress is ignored. No second load follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| map_strap | input | 1 | Memory-map strap; low during reset arms an automatic load |
| sw_reboot | input | 1 | Software reboot request pulse |
| src_data | input | 8 | Byte returned by the external source |
| src_valid | input | 1 | src_data is valid for the current address |
| src_sel_n | output | 1 | Active-low boot source select, low while fetching |
| src_addr | output | 16 | Byte address presented to the source |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 3 | Program memory word address (clog2 of WORDS) |
| pm_wdata | output | 24 | Assembled program word |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the last word is written |

## Verification
Each output is due at a known cycle, and each check samples at that cycle:
- src_sel_n goes low one rising edge after an automatic start and two rising edges after a reboot pulse is sampled.
- pm_we follows the edge that accepts a third byte by one cycle.
- done follows the last write by exactly one cycle.

Inputs change on the falling clock edge. A monitor samples a moment later in the same half-period, so every accepted byte, written word and done pulse is checked in the cycle it is valid. The tasks wait a whole number of falling edges before they compare start latency, held addresses and final counts.

// File: rtl/bootld_pkg.sv
// Package: shared types for the boot loader sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package bootld_pkg;

    // Sequencer phases: waiting, fetching bytes, final word-write cycle.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FETCH  = 2'd1,
        PH_FINISH = 2'd2
    } bootld_phase_t;

endpackage

// File: rtl/bootld_trigger.sv
// Module: bootld_trigger
// Holds a start request until the sequencer accepts it. The request is
// armed during reset when the strap is low, and by a reboot pulse seen
// while the sequencer is idle.
// Assumes: synchronous active-low reset; go is high for one cycle when
// the sequencer leaves idle.
module bootld_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic map_strap,
    input  logic sw_reboot,
    input  logic idle,
    input  logic go,
    output logic pend
);

    // Request flag: armed from strap in reset, from reboot when idle, cleared on go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= ~map_strap;
        end else if (go) begin
            pend <= 1'b0;
        end else if (sw_reboot && idle) begin
            pend <= 1'b1;
        end
    end

    // R10: a reboot pulse during a load never leaves a request behind.
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && sw_reboot) |=> !pend);

endmodule

// File: rtl/bootld_fetch.sv
// Module: bootld_fetch
// Phase controller and byte address counter. It starts on a pending
// request, moves the address on for every accepted byte, and leaves
// fetching after the last byte. A done pulse follows one cycle later.
// Assumes: last_byte is asserted only together with an accepted byte.
module bootld_fetch
    import bootld_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              src_valid,
    input  logic              last_byte,
    output bootld_phase_t     phase,
    output logic [ADDR_W-1:0] src_addr,
    output logic              accept,
    output logic              go,
    output logic              done
);

    // Byte handshake and start acceptance, both decoded from the phase.
    always_comb begin
        accept = (phase == PH_FETCH) && src_valid;
        go     = (phase == PH_IDLE) && start;
    end

    // Phase register, byte address counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            src_addr <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_FETCH;
                        src_addr <= '0;
                    end
                end
                PH_FETCH: begin
                    if (src_valid) begin
                        src_addr <= src_addr + ADDR_W'(1);
                        if (last_byte) begin
                            phase <= PH_FINISH;
                        end
                    end
                end
                PH_FINISH: begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R6: each accepted byte, other than the last, moves the address on by one.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last_byte) |=> (src_addr == $past(src_addr) + ADDR_W'(1)));

    // R8: no valid byte means the address holds and fetching goes on.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && !src_valid) |=> ($stable(src_addr) && phase == PH_FETCH));

endmodule

// File: rtl/bootld_pack.sv
// Module: bootld_pack
// Gathers LANES bytes, first byte most significant, into one word. It
// writes the word one cycle after the final byte arrives and counts
// words to flag the last byte of the load.
// Assumes: LANES >= 3; clear is high for one cycle before each load.
module bootld_pack #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 3,
    parameter int WORDS  = 8,
    parameter int PM_AW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    accept,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic                    last_byte,
    output logic                    pm_we,
    output logic [PM_AW-1:0]        pm_addr,
    output logic [BYTE_W*LANES-1:0] pm_wdata
);

    localparam int HOLD_W = BYTE_W * (LANES - 1);
    localparam int SLOT_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [HOLD_W-1:0] hold;
    logic [SLOT_W-1:0] slot;
    logic [PM_AW-1:0]  word_idx;
    logic              slot_full;

    // Word boundary and end-of-load detection.
    always_comb begin
        slot_full = (slot == SLOT_W'(LANES - 1));
        last_byte = accept && slot_full && (word_idx == PM_AW'(WORDS - 1));
    end

    // Byte shift register, lane counter, word counter and write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            slot     <= '0;
            word_idx <= '0;
            pm_we    <= 1'b0;
            pm_addr  <= '0;
            pm_wdata <= '0;
        end else begin
            pm_we <= 1'b0;
            if (clear) begin
                slot     <= '0;
                word_idx <= '0;
            end else if (accept) begin
                if (slot_full) begin
                    pm_we    <= 1'b1;
                    pm_wdata <= {hold, byte_in};
                    pm_addr  <= word_idx;
                    word_idx <= word_idx + PM_AW'(1);
                    slot     <= '0;
                end else begin
                    hold <= {hold[HOLD_W-BYTE_W-1:0], byte_in};
                    slot <= slot + SLOT_W'(1);
                end
            end
        end
    end

    // R7: at least LANES bytes separate two writes, so a write never lasts two cycles.
    p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we |=> !pm_we);

endmodule

// File: rtl/bootld_top.sv
// Module: bootld_top
// Boot loader sequencer. It copies WORDS program words from a byte-wide
// source into a wide program RAM. A load starts from the reset strap or
// from a software reboot pulse.
// Assumes: the source holds src_data for src_addr while src_valid is high.
module bootld_top
    import bootld_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int LANES  = 3,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int PM_AW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_strap,
    input  logic              sw_reboot,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_sel_n,
    output logic [ADDR_W-1:0] src_addr,
    output logic              pm_we,
    output logic [PM_AW-1:0]  pm_addr,
    output logic [WORD_W-1:0] pm_wdata,
    output logic              busy,
    output logic              done
);

    bootld_phase_t phase;
    logic          pend;
    logic          go;
    logic          accept;
    logic          last_byte;
    logic          idle;

    // Phase-derived outputs: select while fetching, busy while not idle.
    always_comb begin
        idle      = (phase == PH_IDLE);
        busy      = !idle;
        src_sel_n = (phase != PH_FETCH);
    end

    bootld_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_strap (map_strap),
        .sw_reboot (sw_reboot),
        .idle      (idle),
        .go        (go),
        .pend      (pend)
    );

    bootld_fetch #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pend),
        .src_valid (src_valid),
        .last_byte (last_byte),
        .phase     (phase),
        .src_addr  (src_addr),
        .accept    (accept),
        .go        (go),
        .done      (done)
    );

    bootld_pack #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES),
        .WORDS  (WORDS),
        .PM_AW  (PM_AW)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (go),
        .accept    (accept),
        .byte_in   (src_data),
        .last_byte (last_byte),
        .pm_wdata  (pm_wdata),
        .pm_we     (pm_we),
        .pm_addr   (pm_addr)
    );

    // R9: done follows the final word write by exactly one cycle.
    p_done_after_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pm_we));

    // R3: with no load in progress, the program memory is never written.
    p_idle_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> !pm_we);

endmodule

// File: tb/sim_bootld_top.sv
`timescale 1ns/1ps
// Directed bench for bootld_top: one task per scenario.
module sim_bootld_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 8;
    localparam int PM_AW      = 3;
    localparam int WDOG_LIM   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_strap = 1'b1;
    logic        sw_reboot = 1'b0;
    logic [7:0]  src_data;
    logic        src_valid = 1'b0;
    logic        src_sel_n;
    logic [15:0] src_addr;
    logic        pm_we;
    logic [PM_AW-1:0] pm_addr;
    logic [23:0] pm_wdata;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int seed = 1;
    int stall_div = 0;
    bit force_low = 1'b0;
    int exp_byte = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int last_we = 0;
    bit sel_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Content of the source at an address for the current seed.
    function automatic logic [7:0] byte_at(input int a, input int s);
        int v;
        v = a * 37 + s * 59 + 11;
        return 8'(v ^ (v >> 5));
    endfunction

    // Word k, with the first byte in the top bits.
    function automatic logic [23:0] exp_word(input int k);
        return {byte_at(3*k, seed), byte_at(3*k+1, seed), byte_at(3*k+2, seed)};
    endfunction

    assign src_data = byte_at(int'(src_addr), seed);

    bootld_top #(.WORDS(WORDS)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_strap (map_strap),
        .sw_reboot (sw_reboot),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_sel_n (src_sel_n),
        .src_addr  (src_addr),
        .pm_we     (pm_we),
        .pm_addr   (pm_addr),
        .pm_wdata  (pm_wdata),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #3;
    endtask

    task automatic clear_model();
        exp_byte = 0;
        wr_cnt   = 0;
        done_cnt = 0;
        sel_seen = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_cnt == 0; i++) step(1);
        chk(done_cnt == 1, "R9 load completes", done_cnt, 1);
    endtask

    // Source pacing, then a monitor of every accepted byte, write and done pulse.
    always @(negedge clk) begin
        cyc++;
        src_valid <= !force_low && (stall_div == 0 || (cyc % stall_div) == 0);
        #1;
        if (rst_n) begin
            if (!src_sel_n) sel_seen = 1'b1;
            if (!src_sel_n && src_valid) begin
                chk(src_addr == 16'(exp_byte), "R6 byte address", int'(src_addr), exp_byte);
                exp_byte++;
            end
            if (pm_we) begin
                chk(pm_addr == PM_AW'(wr_cnt), "R7 word address", int'(pm_addr), wr_cnt);
                chk(pm_wdata == exp_word(wr_cnt), "R7 packed word", int'(pm_wdata), int'(exp_word(wr_cnt)));
                wr_cnt++;
                last_we = cyc;
            end
            if (done) begin
                chk(cyc == last_we + 1, "R9 done timing", cyc, last_we + 1);
                chk(src_sel_n == 1'b1, "R5 select released at done", int'(src_sel_n), 1);
                done_cnt++;
            end
        end
        if (cyc > WDOG_LIM) begin
            chk(1'b0, "watchdog", cyc, WDOG_LIM);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // R1 and R3: strap high, the block stays idle.
    task automatic t_strap_idle();
        map_strap = 1'b1;
        rst_n = 1'b0;
        step(4);
        chk(src_sel_n == 1'b1 && !pm_we && !busy && !done, "R1 reset outputs",
            int'({src_sel_n, pm_we, busy, done}), 8);
        clear_model();
        rst_n = 1'b1;
        step(1);
        chk(src_sel_n == 1'b1 && !busy, "R1 idle after reset", int'({src_sel_n, busy}), 2);
        step(30);
        chk(!sel_seen, "R3 no select with strap high", int'(sel_seen), 0);
        chk(wr_cnt == 0 && done_cnt == 0, "R3 no write with strap high", wr_cnt + done_cnt, 0);
    endtask

    // R2: strap low, automatic load at full speed.
    task automatic t_auto_boot();
        seed = 1;
        stall_div = 0;
        map_strap = 1'b0;
        rst_n = 1'b0;
        step(4);
        clear_model();
        rst_n = 1'b1;
        step(1);
        chk(src_sel_n == 1'b0, "R2 auto start after reset", int'(src_sel_n), 0);
        map_strap = 1'b1;
        wait_done();
        chk(wr_cnt == WORDS, "R7 all words written", wr_cnt, WORDS);
        chk(exp_byte == 3 * WORDS, "R6 byte count", exp_byte, 3 * WORDS);
        step(10);
        chk(done_cnt == 1 && src_sel_n && !busy, "R9 single done, idle after", done_cnt, 1);
    endtask

    // R4 and R10: reboot from idle with a slow source; a second pulse mid-load is ignored.
    task automatic t_reboot_stalled();
        seed = 2;
        stall_div = 3;
        clear_model();
        sw_reboot = 1'b1;
        step(1);
        sw_reboot = 1'b0;
        chk(src_sel_n == 1'b1, "R4 not yet fetching", int'(src_sel_n), 1);
        step(1);
        chk(src_sel_n == 1'b0 && busy, "R4 reboot starts load", int'(src_sel_n), 0);
        for (int i = 0; i < 500 && wr_cnt < 2; i++) step(1);
        chk(src_sel_n == 1'b0, "R5 select held mid-load", int'(src_sel_n), 0);
        sw_reboot = 1'b1;
        step(1);
        sw_reboot = 1'b0;
        wait_done();
        chk(wr_cnt == WORDS, "R7 words with stalls", wr_cnt, WORDS);
        step(20);
        chk(done_cnt == 1 && !busy && src_sel_n, "R10 reboot during load ignored", done_cnt, 1);
        chk(wr_cnt == WORDS, "R10 no extra writes", wr_cnt, WORDS);
    endtask

    // R8: source holds valid low, the loader waits and then resumes.
    task automatic t_stall();
        seed = 3;
        stall_div = 0;
        force_low = 1'b1;
        clear_model();
        sw_reboot = 1'b1;
        step(1);
        sw_reboot = 1'b0;
        step(12);
        chk(src_sel_n == 1'b0, "R8 select held while stalled", int'(src_sel_n), 0);
        chk(src_addr == 16'd0, "R8 address held", int'(src_addr), 0);
        chk(wr_cnt == 0, "R8 no write while stalled", wr_cnt, 0);
        force_low = 1'b0;
        wait_done();
        chk(wr_cnt == WORDS, "R8 load finishes after stall", wr_cnt, WORDS);
    endtask

    initial begin
        t_strap_idle();
        t_auto_boot();
        t_reboot_stalled();
        t_stall();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule